// File: doc/BRIEF.md
# Repeatable String Transfer Engine

This block carries out the three data-moving string operations of a 16-bit segmented machine: copy an element from the source string to the destination string, load an element from the source string into the accumulator, and store the accumulator into the destination string. An element is a byte or a 16-bit word. The source lives at segment DS with offset SI, the destination at segment ES with offset DI. A direction flag decides whether the offsets climb or fall after each element. A repeat option runs the operation once per unit of the count register CX.

A controller issues a one-cycle start with the operation, the element size, the repeat and direction settings, and the starting register values. The engine then steps through a byte-wide memory port, one byte access per cycle. When it finishes it raises done for one cycle. At that point the outputs hold the final SI, DI, CX and AX, together with the number of machine states the operation is charged. Those results stay in place until the next start is accepted.

Top module: `strx_engine`

## Requirements
- R1: With operation code 2'b00 (move), each element read from physical address DS*16 + SI (modulo 2^20) is written unchanged to physical address ES*16 + DI (modulo 2^20). Read and write never happen in the same cycle.
- R2: With operation code 2'b01 (load), a byte element replaces AL and leaves AH as it was, and a word element replaces all of AX. Only SI moves, DI stays as it was, and the port is never written.
- R3: With operation code 2'b10 (store), AL (byte) or AX (word) is written at ES:DI. Only DI moves, AX and SI stay as they were, and the port is never read.
- R4: After each element, a pointer that the operation uses moves by N (1 for a byte, 2 for a word). It rises when df is 0 and falls when df is 1, wrapping modulo 2^16.
- R5: A word element takes its low byte at the pointer offset and its high byte at the pointer offset plus 1, modulo 2^16. The low byte is handled in full (read and write) before the high byte.
- R6: Each element transferred adds to state_cnt 18 for a move, 12 for a load and 11 for a store.
- R7: With rep set, state_cnt also receives 9, once per operation. CX falls by one per element, and the operation ends after the element that brings CX to zero, so exactly CX elements move.
- R8: With rep set and CX equal to zero at start, no memory access is made. SI, DI, CX and AX keep their start values, and state_cnt is 9.
- R9: With rep clear, exactly one element moves whatever CX holds, and CX is returned unchanged.
- R10: After reset, busy, done, mem_rd, mem_wr and state_cnt are 0. done is a single-cycle pulse at the end of each operation, after which busy is 0 and the results stay unchanged.
- R11: A start pulse arriving while busy is 1 is ignored, and the running operation completes with the results it would have had without that pulse.
- R12: A start with operation code 2'b11 is ignored: busy and done stay 0 and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | 00 move, 01 load, 10 store, 11 reserved |
| wide | input | 1 | 1 selects word elements, 0 byte elements |
| rep | input | 1 | Repeat the operation CX times |
| df | input | 1 | Direction: 0 increment, 1 decrement |
| si_in | input | 16 | Starting source offset |
| di_in | input | 16 | Starting destination offset |
| cx_in | input | 16 | Starting count |
| ds_in | input | 16 | Source segment |
| es_in | input | 16 | Destination segment |
| ax_in | input | 16 | Starting accumulator |
| mem_addr | output | 20 | Physical byte address of the current access |
| mem_rd | output | 1 | Read strobe; data sampled at the end of the cycle |
| mem_rdata | input | 8 | Read data, valid in the cycle of mem_rd |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| si_out | output | 16 | Current source offset |
| di_out | output | 16 | Current destination offset |
| cx_out | output | 16 | Current count |
| ax_out | output | 16 | Current accumulator |
| state_cnt | output | 24 | States charged to the operation |

## Verification
Random operations mix all three kinds, both sizes, both directions and repeat counts from 0 to 12. Segments and offsets are random, and the memory is compared byte for byte against a bench model. This separates errors in pointer stepping from errors in data steering and cost accounting. Directed cases hit specific faults:
- offsets of FFFF and 0000 with word elements, which expose missing 16-bit wrap on the high byte;
- high segments, which expose a dropped top address nibble;
- overlapping source and destination, which exposes byte ordering within a word;
- a zero repeat count;
- a start pulse landing during an operation;
- the reserved code.

// File: rtl/strx_pkg.sv
package strx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_MOVE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_NONE  = 2'b11
  } strx_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_STEP  = 3'd4,
    ST_FIN   = 3'd5
  } strx_st_e;

endpackage

// File: rtl/strx_phys_addr.sv
module strx_phys_addr #(
  parameter int PTR_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W   = PTR_W + SEG_SHIFT
) (
  input  logic [PTR_W-1:0]  seg,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              hi,
  output logic [ADDR_W-1:0] addr
);

  logic [PTR_W-1:0] offset;

  // the high byte offset wraps inside the segment
  always_comb begin
    offset = ptr + {{(PTR_W-1){1'b0}}, hi};
    addr   = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offset};
  end

endmodule

// File: rtl/strx_ptr_reg.sv
module strx_ptr_reg #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  input  logic             dec,
  input  logic [1:0]       step_n,
  output logic [PTR_W-1:0] q
);

  logic [PTR_W-1:0] q_d;
  logic [PTR_W-1:0] delta;

  always_comb begin
    delta = {{(PTR_W-2){1'b0}}, step_n};
    q_d   = q;
    if (load) begin
      q_d = load_val;
    end else if (step) begin
      q_d = dec ? (q - delta) : (q + delta);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

  // R4: a pointer moves only on load or step
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(q));

  // R4: a step changes the pointer
  assert_ptr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && step_n != 2'b00) |=> !$stable(q));

endmodule

// File: rtl/strx_seq.sv
module strx_seq
  import strx_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int CNT_W      = 24,
  parameter int MOVE_COST  = 18,
  parameter int LOAD_COST  = 12,
  parameter int STORE_COST = 11,
  parameter int REP_COST   = 9,
  localparam int WORD_W    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              wide,
  input  logic              rep,
  input  logic              df,
  input  logic [PTR_W-1:0]  cx_in,
  input  logic [PTR_W-1:0]  ds_in,
  input  logic [PTR_W-1:0]  es_in,
  input  logic [WORD_W-1:0] ax_in,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              ptr_load,
  output logic              step_si,
  output logic              step_di,
  output logic [1:0]        step_n,
  output logic              dec,
  output logic              hi,
  output logic              rd,
  output logic              wr,
  output logic              sel_dst,
  output logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ds_q,
  output logic [PTR_W-1:0]  es_q,
  output logic [PTR_W-1:0]  cx,
  output logic [WORD_W-1:0] ax,
  output logic [CNT_W-1:0]  cnt
);

  strx_st_e          st_q, st_d;
  strx_op_e          op_q, op_d;
  logic              wide_q, wide_d;
  logic              rep_q, rep_d;
  logic              df_q, df_d;
  logic              hi_q, hi_d;
  logic [PTR_W-1:0]  cx_q, cx_d;
  logic [PTR_W-1:0]  ds_d, es_d;
  logic [WORD_W-1:0] ax_q, ax_d;
  logic [BYTE_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  cost;

  always_comb begin
    case (op_q)
      OP_MOVE:  cost = CNT_W'(MOVE_COST);
      OP_LOAD:  cost = CNT_W'(LOAD_COST);
      OP_STORE: cost = CNT_W'(STORE_COST);
      default:  cost = '0;
    endcase
  end

  // next-state process
  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    wide_d   = wide_q;
    rep_d    = rep_q;
    df_d     = df_q;
    hi_d     = hi_q;
    cx_d     = cx_q;
    ds_d     = ds_q;
    es_d     = es_q;
    ax_d     = ax_q;
    buf_d    = buf_q;
    cnt_d    = cnt_q;
    ptr_load = 1'b0;
    step_si  = 1'b0;
    step_di  = 1'b0;
    rd       = 1'b0;
    wr       = 1'b0;
    wdata    = '0;
    case (st_q)
      ST_IDLE: begin
        if (start && (strx_op_e'(op) != OP_NONE)) begin
          st_d     = ST_SETUP;
          op_d     = strx_op_e'(op);
          wide_d   = wide;
          rep_d    = rep;
          df_d     = df;
          cx_d     = cx_in;
          ds_d     = ds_in;
          es_d     = es_in;
          ax_d     = ax_in;
          ptr_load = 1'b1;
          cnt_d    = rep ? CNT_W'(REP_COST) : '0;
        end
      end
      ST_SETUP: begin
        hi_d = 1'b0;
        if (rep_q && (cx_q == '0)) begin
          st_d = ST_FIN;
        end else begin
          st_d = (op_q == OP_STORE) ? ST_WR : ST_RD;
        end
      end
      ST_RD: begin
        rd = 1'b1;
        if (op_q == OP_MOVE) begin
          buf_d = mem_rdata;
        end else if (hi_q) begin
          ax_d[WORD_W-1:BYTE_W] = mem_rdata;
        end else begin
          ax_d[BYTE_W-1:0] = mem_rdata;
        end
        if (op_q == OP_MOVE) begin
          st_d = ST_WR;
        end else if (wide_q && !hi_q) begin
          hi_d = 1'b1;
        end else begin
          st_d = ST_STEP;
        end
      end
      ST_WR: begin
        wr = 1'b1;
        if (op_q == OP_MOVE) begin
          wdata = buf_q;
        end else begin
          wdata = hi_q ? ax_q[WORD_W-1:BYTE_W] : ax_q[BYTE_W-1:0];
        end
        if (wide_q && !hi_q) begin
          hi_d = 1'b1;
          st_d = (op_q == OP_MOVE) ? ST_RD : ST_WR;
        end else begin
          st_d = ST_STEP;
        end
      end
      ST_STEP: begin
        step_si = (op_q != OP_STORE);
        step_di = (op_q != OP_LOAD);
        cnt_d   = cnt_q + cost;
        if (rep_q) begin
          cx_d = cx_q - PTR_W'(1);
        end
        st_d = rep_q ? ST_SETUP : ST_FIN;
      end
      ST_FIN: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_MOVE;
      wide_q <= 1'b0;
      rep_q  <= 1'b0;
      df_q   <= 1'b0;
      hi_q   <= 1'b0;
      cx_q   <= '0;
      ds_q   <= '0;
      es_q   <= '0;
      ax_q   <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      wide_q <= wide_d;
      rep_q  <= rep_d;
      df_q   <= df_d;
      hi_q   <= hi_d;
      cx_q   <= cx_d;
      ds_q   <= ds_d;
      es_q   <= es_d;
      ax_q   <= ax_d;
      buf_q  <= buf_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = (st_q == ST_FIN);
  assign step_n  = wide_q ? 2'd2 : 2'd1;
  assign dec     = df_q;
  assign hi      = hi_q;
  assign sel_dst = (st_q == ST_WR);
  assign cx      = cx_q;
  assign ax      = ax_q;
  assign cnt     = cnt_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_load_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_LOAD) |-> !wr);

  assert_store_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_STORE) |-> !rd);

  assert_cx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rep_q) |=> $stable(cx_q));

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETUP && rep_q && cx_q == '0) |=> done);

  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/strx_engine.sv
module strx_engine
  import strx_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int SEG_SHIFT  = 4,
  parameter int CNT_W      = 24,
  parameter int MOVE_COST  = 18,
  parameter int LOAD_COST  = 12,
  parameter int STORE_COST = 11,
  parameter int REP_COST   = 9,
  localparam int ADDR_W    = PTR_W + SEG_SHIFT,
  localparam int WORD_W    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              wide,
  input  logic              rep,
  input  logic              df,
  input  logic [PTR_W-1:0]  si_in,
  input  logic [PTR_W-1:0]  di_in,
  input  logic [PTR_W-1:0]  cx_in,
  input  logic [PTR_W-1:0]  ds_in,
  input  logic [PTR_W-1:0]  es_in,
  input  logic [WORD_W-1:0] ax_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [PTR_W-1:0]  si_out,
  output logic [PTR_W-1:0]  di_out,
  output logic [PTR_W-1:0]  cx_out,
  output logic [WORD_W-1:0] ax_out,
  output logic [CNT_W-1:0]  state_cnt
);

  localparam int NPTR = 2;  // index 0 source, index 1 destination

  logic [1:0]        rst_sync;
  logic              rst_ni;
  logic              ptr_load;
  logic              step_si, step_di, dec, hi, sel_dst;
  logic [1:0]        step_n;
  logic [PTR_W-1:0]  ds_q, es_q;
  logic [PTR_W-1:0]  init_v [NPTR];
  logic [PTR_W-1:0]  seg_v  [NPTR];
  logic [PTR_W-1:0]  ptr_v  [NPTR];
  logic              step_v [NPTR];
  logic [ADDR_W-1:0] addr_v [NPTR];

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync[1];

  strx_seq #(
    .PTR_W(PTR_W), .CNT_W(CNT_W), .MOVE_COST(MOVE_COST),
    .LOAD_COST(LOAD_COST), .STORE_COST(STORE_COST), .REP_COST(REP_COST)
  ) u_seq (
    .clk(clk), .rst_n(rst_ni), .start(start), .op(op), .wide(wide),
    .rep(rep), .df(df), .cx_in(cx_in), .ds_in(ds_in), .es_in(es_in),
    .ax_in(ax_in), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .ptr_load(ptr_load), .step_si(step_si), .step_di(step_di),
    .step_n(step_n), .dec(dec), .hi(hi), .rd(mem_rd), .wr(mem_wr),
    .sel_dst(sel_dst), .wdata(mem_wdata), .ds_q(ds_q), .es_q(es_q),
    .cx(cx_out), .ax(ax_out), .cnt(state_cnt)
  );

  assign init_v[0] = si_in;
  assign init_v[1] = di_in;
  assign seg_v[0]  = ds_q;
  assign seg_v[1]  = es_q;
  assign step_v[0] = step_si;
  assign step_v[1] = step_di;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    strx_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_ni), .load(ptr_load), .load_val(init_v[g]),
      .step(step_v[g]), .dec(dec), .step_n(step_n), .q(ptr_v[g])
    );
    strx_phys_addr #(.PTR_W(PTR_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
      .seg(seg_v[g]), .ptr(ptr_v[g]), .hi(hi), .addr(addr_v[g])
    );
  end

  assign mem_addr = sel_dst ? addr_v[1] : addr_v[0];
  assign si_out   = ptr_v[0];
  assign di_out   = ptr_v[1];

  assert_rw_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !(mem_rd && mem_wr));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/strx_engine_tb.sv
module strx_engine_tb;

  localparam int MEM_N = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic        wide, rep, df;
  logic [15:0] si_in, di_in, cx_in, ds_in, es_in, ax_in;
  logic [19:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        busy, done;
  logic [15:0] si_out, di_out, cx_out, ax_out;
  logic [23:0] state_cnt;

  logic [7:0]  mem     [MEM_N];
  logic [7:0]  exp_mem [MEM_N];
  logic        seen_rd, seen_wr;
  logic [19:0] last_rd, last_wr;

  int checks = 0;
  int fails  = 0;

  logic [15:0] e_si, e_di, e_cx, e_ax;
  logic [23:0] e_cnt;
  logic        e_rd, e_wr;
  logic [19:0] e_last_rd, e_last_wr;

  always #5 clk = ~clk;

  strx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .rep(rep), .df(df), .si_in(si_in), .di_in(di_in), .cx_in(cx_in),
    .ds_in(ds_in), .es_in(es_in), .ax_in(ax_in), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .si_out(si_out),
    .di_out(di_out), .cx_out(cx_out), .ax_out(ax_out), .state_cnt(state_cnt)
  );

  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) begin
    if (mem_wr) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      seen_wr <= 1'b1;
      last_wr <= mem_addr;
    end
    if (mem_rd) begin
      seen_rd <= 1'b1;
      last_rd <= mem_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  // bench model of one operation, byte by byte in requirement order
  task automatic model(input logic [1:0] o, input logic w, input logic r,
                       input logic d, input logic [15:0] s, input logic [15:0] t,
                       input logic [15:0] c, input logic [15:0] sd,
                       input logic [15:0] se, input logic [15:0] a);
    int n;
    int cost;
    logic [15:0] step;
    logic [19:0] pa;
    logic [19:0] pb;
    logic [7:0]  bv;
    for (int k = 0; k < MEM_N; k++) exp_mem[k] = mem[k];
    e_si = s; e_di = t; e_ax = a; e_rd = 1'b0; e_wr = 1'b0;
    e_last_rd = '0; e_last_wr = '0;
    cost = (o == 2'b00) ? 18 : (o == 2'b01) ? 12 : 11;   // R6
    n    = r ? int'(c) : 1;                                 // R7 R9
    e_cx = r ? 16'h0000 : c;
    e_cnt = r ? 24'(9 + cost * n) : 24'(cost);
    step = w ? 16'd2 : 16'd1;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < (w ? 2 : 1); b++) begin
        pa = phys(sd, e_si + 16'(b));   // R5 wrap inside segment
        pb = phys(se, e_di + 16'(b));
        if (o == 2'b00) begin
          bv = exp_mem[pa[11:0]];
          exp_mem[pb[11:0]] = bv;
          e_rd = 1'b1; e_last_rd = pa; e_wr = 1'b1; e_last_wr = pb;
        end else if (o == 2'b01) begin
          if (b == 0) e_ax[7:0] = exp_mem[pa[11:0]];
          else        e_ax[15:8] = exp_mem[pa[11:0]];
          e_rd = 1'b1; e_last_rd = pa;
        end else begin
          exp_mem[pb[11:0]] = (b == 0) ? e_ax[7:0] : e_ax[15:8];
          e_wr = 1'b1; e_last_wr = pb;
        end
      end
      if (o != 2'b10) e_si = d ? e_si - step : e_si + step;   // R4
      if (o != 2'b01) e_di = d ? e_di - step : e_di + step;
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic w, input logic r,
                        input logic d, input logic [15:0] s, input logic [15:0] t,
                        input logic [15:0] c, input logic [15:0] sd,
                        input logic [15:0] se, input logic [15:0] a,
                        input logic poke);
    int waited;
    int mism;
    string tg;
    @(negedge clk);
    seen_rd = 1'b0; seen_wr = 1'b0;
    op = o; wide = w; rep = r; df = d; si_in = s; di_in = t; cx_in = c;
    ds_in = sd; es_in = se; ax_in = a; start = 1'b1;
    model(o, w, r, d, s, t, c, sd, se, a);
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (poke && waited == 3) begin
        // R11: second request during the operation
        start = 1'b1; op = 2'b10; si_in = ~s; di_in = ~t; cx_in = 16'd1; ax_in = ~a;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk("R10 done reached", {31'd0, done}, 32'd1);
    tg = (o == 2'b00) ? "R1" : (o == 2'b01) ? "R2" : "R3";
    if (poke) tg = "R11";
    chk({tg, " R4 si"}, {16'd0, si_out}, {16'd0, e_si});
    chk({tg, " R4 di"}, {16'd0, di_out}, {16'd0, e_di});
    chk(r ? "R7 cx" : "R9 cx", {16'd0, cx_out}, {16'd0, e_cx});
    chk({tg, " ax"}, {16'd0, ax_out}, {16'd0, e_ax});
    chk(r ? "R7 R6 state_cnt" : "R6 state_cnt", {8'd0, state_cnt}, {8'd0, e_cnt});
    mism = 0;
    for (int k = 0; k < MEM_N; k++) if (mem[k] !== exp_mem[k]) mism++;
    chk({tg, " R5 memory image mismatches"}, mism, 0);
    chk({tg, " read seen"}, {31'd0, seen_rd}, {31'd0, e_rd});
    chk({tg, " write seen"}, {31'd0, seen_wr}, {31'd0, e_wr});
    if (e_rd) chk({tg, " R1 last read address"}, {12'd0, last_rd}, {12'd0, e_last_rd});
    if (e_wr) chk({tg, " R1 last write address"}, {12'd0, last_wr}, {12'd0, e_last_wr});
    @(negedge clk);
    chk("R10 done single cycle", {31'd0, done}, 32'd0);
    chk("R10 busy clear", {31'd0, busy}, 32'd0);
    chk("R10 si held", {16'd0, si_out}, {16'd0, e_si});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    logic [15:0] hold_si;
    unused_seed = $urandom(32'h5eed_0042);
    for (int k = 0; k < MEM_N; k++) mem[k] = 8'($urandom);
    seen_rd = 1'b0; seen_wr = 1'b0; last_rd = '0; last_wr = '0;
    start = 1'b0; op = 2'b00; wide = 1'b0; rep = 1'b0; df = 1'b0;
    si_in = '0; di_in = '0; cx_in = '0; ds_in = '0; es_in = '0; ax_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R10 reset done", {31'd0, done}, 32'd0);
    chk("R10 reset mem_rd", {31'd0, mem_rd}, 32'd0);
    chk("R10 reset mem_wr", {31'd0, mem_wr}, 32'd0);
    chk("R10 reset state_cnt", {8'd0, state_cnt}, 32'd0);

    // directed corner cases
    run_op(2'b00, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0100, 16'd7, 16'h0000, 16'h0000, 16'h1234, 1'b0); // R5 R9 wrap
    run_op(2'b10, 1'b1, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'd3, 16'h0000, 16'hF000, 16'hBEEF, 1'b0); // R3 R4 decrement wrap
    run_op(2'b01, 1'b0, 1'b1, 1'b0, 16'h0010, 16'h0020, 16'd4, 16'hF0F0, 16'h0000, 16'hAA55, 1'b0); // R2 byte keeps AH
    run_op(2'b01, 1'b1, 1'b0, 1'b1, 16'h0040, 16'h0020, 16'd0, 16'hFFFF, 16'h0000, 16'h0000, 1'b0); // R2 word, R9 cx zero no-repeat
    run_op(2'b00, 1'b1, 1'b1, 1'b0, 16'h0200, 16'h0201, 16'd5, 16'h0000, 16'h0000, 16'h0000, 1'b0); // R5 overlap order
    run_op(2'b00, 1'b0, 1'b1, 1'b0, 16'h0300, 16'h0400, 16'd0, 16'h0000, 16'h0000, 16'h7777, 1'b0); // R8 zero count
    run_op(2'b00, 1'b0, 1'b1, 1'b0, 16'h0500, 16'h0600, 16'd6, 16'h0000, 16'h0000, 16'h0000, 1'b1); // R11 poke

    // R12: reserved code is ignored
    hold_si = si_out;
    @(negedge clk);
    op = 2'b11; si_in = 16'h5A5A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 busy stays low", {31'd0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R12 done stays low", {31'd0, done}, 32'd0);
    chk("R12 si unchanged", {16'd0, si_out}, {16'd0, hold_si});

    // random mix
    for (int i = 0; i < 40; i++) begin
      run_op(2'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom),
             16'($urandom), 16'($urandom), 16'($urandom % 13),
             16'($urandom), 16'($urandom), 16'($urandom), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule